// File: doc/BRIEF.md
# Boot-Sector Flash Command Controller

This block is the control core of a small boot-sector flash memory. The host reaches it through a chip-enable, write-strobe and read-strobe bus. Unlocked command sequences start timed program and erase operations. These run against an array held in registers. While the array is busy, a read returns a status byte instead of array data: bit 7 polls the data, bit 6 toggles on each read, and bit 5 flags a failed program. The ready/busy output shows the same state as a pin.

The array is split into seven sectors of unequal size. A parameter places the small boot sectors at the low or the high end of the address space. Each sector can be locked by a protection input, and a temporary-unprotect input lifts all locks while it is high. An erase can be paused so that the host can read, or program, outside the sectors being erased, and then continued. A low-supply input blocks every write. The asynchronous reset aborts any operation but leaves the array contents alone.

Sizes are scaled down for simulation. One "kilobyte" of the sector map is 2^KB_SHIFT locations, and the program and erase times are cycle-count parameters. The bus is strobe based, not valid/ready. There is no back-pressure: every clock cycle with ce_n and we_n low is one write, and every cycle with ce_n and oe_n low and we_n high is one read.

Top module: `bootflash_ctrl`

## Requirements
- R1: After rst_n is released, ry_by_n is 1 and reads return array data, so two reads of one address give the same value.
- R2: A program takes four writes: 0xAA to address 0x55, then 0x55 to address 0xAA, then 0xA0, then the data to the target address. These addresses are the low 8 bits of 0x555 and 0x2AA. ry_by_n is 0 for exactly PGM_CYC cycles after the data write. The location then holds old AND data. Any write that breaks a sequence returns the decoder to idle with no effect.
- R3: During a program, a read returns a status byte. Bit 7 is the complement of data bit 7. Bit 5 is 0. Bits 4..0 are 0. Bit 6 inverts between consecutive reads.
- R4: A program that asks a 0 bit to become 1 ends with bit 5 of the status byte set, and ry_by_n stays 0. A single write of 0xF0 then returns to read mode with ry_by_n 1. No array bit ever goes from 0 to 1 except by erase.
- R5: A sector erase is two unlock pairs with 0x80 between them, followed by 0x30 written to any address in the sector. The block first preprograms the sector to 0x00, walking all DEPTH addresses at one per cycle. It then waits ERS_CYC cycles and sets the sector to all ones. ry_by_n is 0 for DEPTH+ERS_CYC cycles, and other sectors are unchanged.
- R6: A chip erase uses the same prefix ending in 0x10 written to address 0x55. It erases every unprotected sector, with the same busy time as R5.
- R7: With TOP_BOOT=0, sectors in kilobyte units are 0-15, 16-23, 24-31, 32-63, 64-127, 128-191 and 192-255. With TOP_BOOT=1 the map is mirrored.
- R8: During an erase, the status byte has bits 7 and 5 at 0, and bit 6 toggles between reads.
- R9: Writing 0xB0 after an unlock pair, during an erase, suspends it. ry_by_n is 1 on the next cycle. Reads outside the erasing sector return array data. Reads inside it return the status byte with bit 6 frozen.
- R10: While an erase is suspended, a program outside the erasing sector runs normally and then returns to the suspended state. A program inside the erasing sector is ignored, and ry_by_n stays 1.
- R11: Writing 0x30 after an unlock pair, while suspended, resumes the erase. The busy time after the resume equals the erase cycles that had not yet run.
- R12: When prot_mask[s] is 1 and unprot_tmp is 0, a program or sector erase aimed at sector s is ignored: ry_by_n stays 1 and the data is unchanged. A chip erase skips sector s. When unprot_tmp is 1, the lock is lifted.
- R13: While low_vcc is 1, writes are ignored and do not advance a command sequence.
- R14: Asserting rst_n mid-erase aborts it. ry_by_n goes to 1, and locations already preprogrammed read 0x00 while the others keep their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts operations, keeps the array |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; one write per cycle low |
| oe_n | input | 1 | Read strobe, active low; one read per cycle low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DW | Write data or command code |
| rdata | output | DW | Array data or status byte during a read, else 0 |
| ry_by_n | output | 1 | 1 when ready, 0 while an operation runs or after a failed program |
| prot_mask | input | 7 | Per-sector lock, bit s for sector s |
| unprot_tmp | input | 1 | Lifts all sector locks while 1 |
| low_vcc | input | 1 | Blocks all writes while 1 |

## Verification
A wrong decoder state shows up as a command that is silently dropped or wrongly run. It is seen at the first read after the sequence, or as ry_by_n failing to fall on the cycle after the final write. Wrong timer or preprogram-pointer state moves the ry_by_n rising edge, which is measured to the exact cycle against PGM_CYC, DEPTH+ERS_CYC or the remaining erase work after a resume. A wrong sector map or erase mask shows up on the bytes just either side of a sector boundary once the erase completes. A stuck toggle or error flag shows up on two reads in a row during the operation.

// File: rtl/bootflash_pkg.sv
package bootflash_pkg;
  localparam int NSEC = 7;

  typedef enum logic [2:0] {
    OP_RD, OP_PGM, OP_PRE, OP_ERS, OP_SUSP, OP_PSUS, OP_ERR
  } op_t;

  localparam logic [7:0] K_UNL1 = 8'hAA;
  localparam logic [7:0] K_UNL2 = 8'h55;
  localparam logic [7:0] K_PROG = 8'hA0;
  localparam logic [7:0] K_ERSP = 8'h80;
  localparam logic [7:0] K_SECT = 8'h30;
  localparam logic [7:0] K_CHIP = 8'h10;
  localparam logic [7:0] K_SUSP = 8'hB0;
  localparam logic [7:0] K_RESM = 8'h30;
  localparam logic [7:0] K_RST  = 8'hF0;

  // sector index of a location given in kilobyte units of the map
  function automatic logic [2:0] sec_of(input logic [7:0] kb, input logic top);
    logic [2:0] s;
    if (!top) begin
      if (kb < 8'd16)       s = 3'd0;
      else if (kb < 8'd24)  s = 3'd1;
      else if (kb < 8'd32)  s = 3'd2;
      else if (kb < 8'd64)  s = 3'd3;
      else if (kb < 8'd128) s = 3'd4;
      else if (kb < 8'd192) s = 3'd5;
      else                  s = 3'd6;
    end else begin
      if (kb < 8'd64)       s = 3'd0;
      else if (kb < 8'd128) s = 3'd1;
      else if (kb < 8'd192) s = 3'd2;
      else if (kb < 8'd224) s = 3'd3;
      else if (kb < 8'd232) s = 3'd4;
      else if (kb < 8'd240) s = 3'd5;
      else                  s = 3'd6;
    end
    return s;
  endfunction
endpackage

// File: rtl/fl_cmd_decode.sv
module fl_cmd_decode import bootflash_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              blk,
  input  logic [ADDR_W-1:0] a,
  input  logic [DW-1:0]     d,
  output logic              ev_pgm,
  output logic              ev_sec,
  output logic              ev_chip,
  output logic              ev_susp,
  output logic              ev_resume,
  output logic              ev_reset
);
  localparam logic [ADDR_W-1:0] UA1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UA2 = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {D_IDLE, D_AA, D_55, D_A0, D_80, D_80AA, D_8055} dst_t;
  dst_t st, nxt;

  logic [7:0] c;
  logic       u1, u2, isrst;
  assign c     = d[7:0];
  assign u1    = (c == K_UNL1) && (a == UA1);
  assign u2    = (c == K_UNL2) && (a == UA2);
  assign isrst = (c == K_RST);

  always_comb begin
    nxt = st;
    ev_pgm = 1'b0; ev_sec = 1'b0; ev_chip = 1'b0;
    ev_susp = 1'b0; ev_resume = 1'b0; ev_reset = 1'b0;
    if (wr && !blk) begin
      nxt = D_IDLE;
      unique case (st)
        D_IDLE: if (u1) nxt = D_AA; else ev_reset = isrst;
        D_AA:   if (u2) nxt = D_55; else ev_reset = isrst;
        D_55: begin
          if (c == K_PROG)      nxt = D_A0;
          else if (c == K_ERSP) nxt = D_80;
          else if (c == K_SUSP) ev_susp = 1'b1;
          else if (c == K_RESM) ev_resume = 1'b1;
          else                  ev_reset = isrst;
        end
        D_A0:   ev_pgm = 1'b1;
        D_80:   if (u1) nxt = D_80AA; else ev_reset = isrst;
        D_80AA: if (u2) nxt = D_8055; else ev_reset = isrst;
        D_8055: begin
          if (c == K_SECT)                 ev_sec = 1'b1;
          else if (c == K_CHIP && a == UA1) ev_chip = 1'b1;
          else                             ev_reset = isrst;
        end
        default: nxt = D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= D_IDLE;
    else        st <= nxt;

  // R2
  one_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_pgm, ev_sec, ev_chip, ev_susp, ev_resume, ev_reset}));
  // R13
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> $stable(st));
endmodule

// File: rtl/fl_array.sv
module fl_array import bootflash_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DW = 8,
  parameter int KB_SHIFT = 0,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              ers_en,
  input  logic [NSEC-1:0]   ers_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [ADDR_W-1:0] vf_addr,
  output logic [DW-1:0]     vf_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] ehit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    assign ehit[g] = ers_en & ers_mask[sec_of(8'(g >> KB_SHIFT), TOP_BOOT)];
    // R4
    no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ers_en |=> (mem[g] & ~$past(mem[g])) == '0);
  end

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++)
      if (ehit[i])                                 mem[i] <= '1;
      else if (wr_en && wr_addr == ADDR_W'(i))     mem[i] <= mem[i] & wr_data;

  assign rd_data = mem[rd_addr];
  assign vf_data = mem[vf_addr];
endmodule

// File: rtl/bootflash_ctrl.sv
module bootflash_ctrl import bootflash_pkg::*; #(
  parameter int KB_SHIFT = 0,
  parameter int DW = 8,
  parameter bit TOP_BOOT = 1'b0,
  parameter int PGM_CYC = 16,
  parameter int ERS_CYC = 64,
  localparam int ADDR_W = 8 + KB_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ry_by_n,
  input  logic [NSEC-1:0]   prot_mask,
  input  logic              unprot_tmp,
  input  logic              low_vcc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PT_W = $clog2(PGM_CYC + 1);
  localparam int ET_W = $clog2(ERS_CYC + 1);

  op_t               op, res_op;
  logic [ADDR_W-1:0] ptr, tgt_a;
  logic [DW-1:0]     tgt_d, ar_rd, ar_vf, stat;
  logic [PT_W-1:0]   ptmr;
  logic [ET_W-1:0]   etmr;
  logic [NSEC-1:0]   emask, lk_mask, sec_oh, new_mask;
  logic              err, tog, busy, wr_req, rd_cyc, vfail;
  logic [2:0]        bus_sec, ptr_sec;
  logic              ev_pgm, ev_sec, ev_chip, ev_susp, ev_resume, ev_reset;
  logic              a_wr, a_ers;
  logic [ADDR_W-1:0] a_wa;
  logic [DW-1:0]     a_wd;

  assign wr_req   = ~ce_n & ~we_n;
  assign rd_cyc   = ~ce_n & ~oe_n & we_n;
  assign bus_sec  = sec_of(8'(addr >> KB_SHIFT), TOP_BOOT);
  assign ptr_sec  = sec_of(8'(ptr >> KB_SHIFT), TOP_BOOT);
  assign lk_mask  = prot_mask & {NSEC{~unprot_tmp}};
  assign sec_oh   = NSEC'(1) << bus_sec;
  assign new_mask = (ev_chip ? {NSEC{1'b1}} : sec_oh) & ~lk_mask;
  assign busy     = (op == OP_PGM) || (op == OP_PRE) || (op == OP_ERS) ||
                    (op == OP_PSUS) || (op == OP_ERR);
  assign ry_by_n  = ~busy;
  assign vfail    = (~ar_vf & tgt_d) != '0;

  fl_cmd_decode #(.ADDR_W(ADDR_W), .DW(DW)) i_dec (
    .clk(clk), .rst_n(rst_n), .wr(wr_req), .blk(low_vcc), .a(addr), .d(wdata),
    .ev_pgm(ev_pgm), .ev_sec(ev_sec), .ev_chip(ev_chip), .ev_susp(ev_susp),
    .ev_resume(ev_resume), .ev_reset(ev_reset));

  assign a_wr  = ((op == OP_PGM || op == OP_PSUS) && ptmr == '0) ||
                 (op == OP_PRE && emask[ptr_sec] && !ev_susp);
  assign a_wa  = (op == OP_PRE) ? ptr : tgt_a;
  assign a_wd  = (op == OP_PRE) ? '0 : tgt_d;
  assign a_ers = (op == OP_ERS) && (etmr == '0) && !ev_susp;

  fl_array #(.ADDR_W(ADDR_W), .DW(DW), .KB_SHIFT(KB_SHIFT), .TOP_BOOT(TOP_BOOT)) i_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr), .wr_addr(a_wa), .wr_data(a_wd),
    .ers_en(a_ers), .ers_mask(emask), .rd_addr(addr), .rd_data(ar_rd),
    .vf_addr(tgt_a), .vf_data(ar_vf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_RD; res_op <= OP_RD; ptr <= '0; tgt_a <= '0; tgt_d <= '0;
      ptmr <= '0; etmr <= '0; emask <= '0; err <= 1'b0; tog <= 1'b0;
    end else begin
      if (rd_cyc && busy) tog <= ~tog;
      unique case (op)
        OP_RD: begin
          if (ev_pgm && !lk_mask[bus_sec]) begin
            op <= OP_PGM; tgt_a <= addr; tgt_d <= wdata; ptmr <= PT_W'(PGM_CYC - 1);
          end else if ((ev_sec || ev_chip) && new_mask != '0) begin
            op <= OP_PRE; emask <= new_mask; ptr <= '0;
          end
        end
        OP_PGM, OP_PSUS: begin
          if (ptmr == '0) begin
            if (vfail)               begin op <= OP_ERR; err <= 1'b1; end
            else if (op == OP_PSUS)  op <= OP_SUSP;
            else                     op <= OP_RD;
          end else ptmr <= ptmr - 1'b1;
        end
        OP_PRE: begin
          if (ev_susp)                        begin op <= OP_SUSP; res_op <= OP_PRE; end
          else if (ptr == ADDR_W'(DEPTH - 1)) begin op <= OP_ERS; etmr <= ET_W'(ERS_CYC - 1); end
          else                                ptr <= ptr + 1'b1;
        end
        OP_ERS: begin
          if (ev_susp)             begin op <= OP_SUSP; res_op <= OP_ERS; end
          else if (etmr == '0)     begin op <= OP_RD; emask <= '0; end
          else                     etmr <= etmr - 1'b1;
        end
        OP_SUSP: begin
          if (ev_resume) op <= res_op;
          else if (ev_pgm && !lk_mask[bus_sec] && !emask[bus_sec]) begin
            op <= OP_PSUS; tgt_a <= addr; tgt_d <= wdata; ptmr <= PT_W'(PGM_CYC - 1);
          end
        end
        OP_ERR: if (ev_reset) begin op <= OP_RD; err <= 1'b0; emask <= '0; end
        default: op <= OP_RD;
      endcase
    end
  end

  always_comb begin
    stat = '0;
    stat[7] = (op == OP_PGM || op == OP_PSUS || op == OP_ERR) ? ~tgt_d[7] : 1'b0;
    stat[6] = tog;
    stat[5] = err;
    if (!rd_cyc)                          rdata = '0;
    else if (busy)                        rdata = stat;
    else if (op == OP_SUSP && emask[bus_sec]) rdata = stat;
    else                                  rdata = ar_rd;
  end

  // R12
  prot_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD && ev_pgm && lk_mask[bus_sec]) |=> ry_by_n);
  // R9
  susp_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_PRE || op == OP_ERS) && ev_susp) |=> ry_by_n);
  // R4
  err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ry_by_n);
  // R3
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> $stable(tog));
endmodule

// File: tb/test_bootflash_ctrl.sv
module test_bootflash_ctrl;
  localparam int DEPTH = 256;
  localparam int PGM_CYC = 16;
  localparam int ERS_CYC = 64;

  logic       clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       ry_by_n, unprot_tmp = 1'b0, low_vcc = 1'b0;
  logic [6:0] prot_mask = '0;
  int         cyc = 0, last_w = 0, nchk = 0, nerr = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bootflash_ctrl #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) i_bootflash_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by_n(ry_by_n),
    .prot_mask(prot_mask), .unprot_tmp(unprot_tmp), .low_vcc(low_vcc));

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    nchk++; nerr++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    finish_run();
  end

  task automatic ck(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1; last_w = cyc;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_rdy(output int busy);
    int n = 0;
    while (!ry_by_n && n < 5000) begin @(negedge clk); n++; end
    busy = cyc - last_w;
  endtask

  task automatic unl();           bw(8'h55, 8'hAA); bw(8'hAA, 8'h55); endtask
  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    unl(); bw(8'h55, 8'hA0); bw(a, d);
  endtask
  task automatic sect_ers(input logic [7:0] a);
    unl(); bw(8'h55, 8'h80); unl(); bw(a, 8'h30);
  endtask
  task automatic chip_ers();
    unl(); bw(8'h55, 8'h80); unl(); bw(8'h55, 8'h10);
  endtask
  task automatic prog_wait(input logic [7:0] a, input logic [7:0] d);
    int b; prog(a, d); wait_rdy(b);
  endtask

  task automatic t_reset();
    logic [7:0] r1, r2;
    ck("R1 ready after reset", ry_by_n, 1);
    brd(8'h07, r1); brd(8'h07, r2);
    ck("R1 array read stable", r1, r2);
  endtask

  task automatic t_chip();
    int b; logic [7:0] r;
    chip_ers(); wait_rdy(b);
    ck("R6 chip erase busy", b, DEPTH + ERS_CYC);
    brd(8'h00, r); ck("R6 addr0 erased", r, 8'hFF);
    brd(8'hC8, r); ck("R6 addrC8 erased", r, 8'hFF);
  endtask

  task automatic t_program();
    int b; logic [7:0] r1, r2;
    prog(8'd40, 8'h3C);
    ck("R2 busy after data write", ry_by_n, 0);
    brd(8'd40, r1); brd(8'd40, r2);
    ck("R3 status bits", r1 & 8'hBF, 8'h80);
    ck("R3 toggle", r1 ^ r2, 8'h40);
    wait_rdy(b);
    ck("R2 program busy time", b, PGM_CYC);
    brd(8'd40, r1); ck("R2 programmed value", r1, 8'h3C);
  endtask

  task automatic t_pgm_err();
    logic [7:0] r1, r2;
    prog_wait(8'd5, 8'h00);
    prog(8'd5, 8'h80);
    repeat (PGM_CYC + 2) @(negedge clk);
    ck("R4 stays busy on failure", ry_by_n, 0);
    brd(8'd5, r1); brd(8'd5, r2);
    ck("R4 error flag and poll bit", r1 & 8'hBF, 8'h20);
    ck("R4 toggle continues", r1 ^ r2, 8'h40);
    bw(8'h00, 8'hF0);
    ck("R4 reset command readies", ry_by_n, 1);
    brd(8'd5, r1); ck("R4 bit not set", r1, 8'h00);
  endtask

  task automatic t_invalid();
    logic [7:0] r;
    bw(8'h55, 8'hAA); bw(8'hAA, 8'h11); bw(8'h55, 8'hA0); bw(8'd10, 8'h00);
    ck("R2 broken sequence idle", ry_by_n, 1);
    brd(8'd10, r); ck("R2 broken sequence no write", r, 8'hFF);
  endtask

  task automatic t_sector_map();
    int b; logic [7:0] r1, r2;
    prog_wait(8'd15, 8'h00); prog_wait(8'd16, 8'h00);
    prog_wait(8'd23, 8'h00); prog_wait(8'd24, 8'h00);
    sect_ers(8'd20);
    brd(8'd20, r1); brd(8'd20, r2);
    ck("R8 erase status bits", r1 & 8'hBF, 8'h00);
    ck("R8 erase toggle", r1 ^ r2, 8'h40);
    wait_rdy(b);
    ck("R5 sector erase busy", b, DEPTH + ERS_CYC);
    brd(8'd15, r1); ck("R7 below sector kept", r1, 8'h00);
    brd(8'd16, r1); ck("R7 first of sector erased", r1, 8'hFF);
    brd(8'd23, r1); ck("R7 last of sector erased", r1, 8'hFF);
    brd(8'd24, r1); ck("R5 next sector kept", r1, 8'h00);
  endtask

  task automatic t_protect();
    int b; logic [7:0] r;
    prot_mask = 7'b0000100;
    prog(8'd25, 8'h00);
    ck("R12 protected program ignored", ry_by_n, 1);
    brd(8'd25, r); ck("R12 protected data kept", r, 8'hFF);
    sect_ers(8'd25);
    ck("R12 protected erase ignored", ry_by_n, 1);
    unprot_tmp = 1;
    prog(8'd25, 8'h0F); wait_rdy(b);
    ck("R12 unprotect busy", b, PGM_CYC);
    brd(8'd25, r); ck("R12 unprotect program", r, 8'h0F);
    unprot_tmp = 0;
    chip_ers(); wait_rdy(b);
    brd(8'd25, r); ck("R12 chip erase skips locked", r, 8'h0F);
    brd(8'd40, r); ck("R12 chip erase others", r, 8'hFF);
    prot_mask = '0;
  endtask

  task automatic t_lowvcc();
    logic [7:0] r;
    low_vcc = 1;
    prog(8'd3, 8'h00);
    ck("R13 blocked program", ry_by_n, 1);
    unl();
    low_vcc = 0;
    bw(8'h55, 8'hA0); bw(8'd3, 8'h00);
    ck("R13 blocked prefix", ry_by_n, 1);
    brd(8'd3, r); ck("R13 data kept", r, 8'hFF);
  endtask

  task automatic t_suspend();
    int b, w, s; logic [7:0] r1, r2;
    sect_ers(8'd140); w = last_w;
    repeat (20) @(negedge clk);
    unl(); bw(8'h55, 8'hB0); s = last_w;
    ck("R9 ready when suspended", ry_by_n, 1);
    brd(8'd40, r1); ck("R9 outside read", r1, 8'hFF);
    brd(8'd140, r1); brd(8'd140, r2);
    ck("R9 inside read status", r1 & 8'hBF, 8'h00);
    ck("R9 frozen toggle", r1, r2);
    prog(8'd41, 8'h12);
    ck("R10 program in suspend busy", ry_by_n, 0);
    wait_rdy(b);
    ck("R10 program in suspend time", b, PGM_CYC);
    brd(8'd41, r1); ck("R10 program in suspend data", r1, 8'h12);
    prog(8'd150, 8'h00);
    ck("R10 erasing sector program ignored", ry_by_n, 1);
    unl(); bw(8'h55, 8'h30);
    ck("R11 busy after resume", ry_by_n, 0);
    wait_rdy(b);
    ck("R11 remaining time", b, DEPTH + ERS_CYC - (s - w - 1));
    brd(8'd140, r1); ck("R11 erase complete", r1, 8'hFF);
    brd(8'd150, r1); ck("R11 erase complete 150", r1, 8'hFF);
    brd(8'd41, r1); ck("R11 other sector kept", r1, 8'h12);
  endtask

  task automatic t_abort();
    int b; logic [7:0] r1, r2;
    prog_wait(8'd127, 8'h5A);
    sect_ers(8'd100);
    repeat (90) @(negedge clk);
    rst_n = 0; @(negedge clk); rst_n = 1;
    ck("R14 ready after abort", ry_by_n, 1);
    brd(8'd64, r1); ck("R14 preprogrammed", r1, 8'h00);
    brd(8'd127, r1); brd(8'd127, r2);
    ck("R14 unreached kept", r1, 8'h5A);
    ck("R14 array mode", r1, r2);
    prog(8'd130, 8'h00); wait_rdy(b);
    ck("R14 commands after abort", b, PGM_CYC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_chip();
    t_program();
    t_pgm_err();
    t_invalid();
    t_sector_map();
    t_protect();
    t_lowvcc();
    t_suspend();
    t_abort();
    finish_run();
  end
endmodule